// File: doc/BRIEF.md
# SMBus Indexed Configuration Target

This block is a small two-wire bus target that holds the configuration of a multi-output clock buffer. It watches the bus clock and data lines with a fast system clock, finds start, repeated-start and stop conditions, and takes part in two kinds of transaction. The first is an indexed block write: the host names a starting byte index and a byte count, then sends the data. The second is an indexed block read: the host sets the index with a short write, turns the bus around with a repeated start, and receives a byte count followed by data from that index onward.

Seven bytes of state sit behind the bus. They hold a drive-mode byte with two high-impedance selections, one enable bit per output, one stoppable bit per output, a reserved byte, an identification byte, a device code, and a writable count that sets the value a block read reports first. Each output gets a run signal that combines its enable bit, its stoppable bit and an active-low output-enable pin. The data line is only ever pulled low, so it can share an open-drain wire.

Top module: `smb_cfg_target`

## Requirements
- R1: The target acknowledges the write address 0xDC and the read address 0xDD. Any other address byte gets no acknowledge, and the target leaves SDA released until the next start.
- R2: A block write sends, in order, the write address, the index N, the count X and X data bytes. Each byte gets an acknowledge, and data byte k is stored at index N+k.
- R3: Data bytes past the count X get no acknowledge and change no register.
- R4: After the read address, the target first sends the count byte (index 6) and then the bytes from index N upward, with the index going up by one per byte. A host not-acknowledge ends the read and releases SDA.
- R5: After reset, indexes 0 to 6 read 0x80, 0x0F, 0x00, 0x00, 0x11, 0x43 and 0x07. All run outputs are high, pd_hiz is 1 and stop_hiz is 0.
- R6: Only these bits accept writes: bits 7 and 6 of index 0, bits 3..0 of indexes 1 and 2, and all of index 6. Every other bit keeps its value, and reserved bits read 0.
- R7: Writes to indexes above 6 are acknowledged and then dropped. Reads from indexes above 6 return 0x00.
- R8: A start or stop in the middle of a byte abandons the transaction. Bytes already acknowledged stay written, and a new start is decoded normally.
- R9: run[i] is high exactly when bit i of index 1 is 1 and either bit i of index 2 is 0 or oe_n[i] is low.
- R10: pd_hiz follows bit 7 of index 0 and stop_hiz follows bit 6 of index 0.
- R11: sda_pull only changes while the synchronised SCL is low. It is low whenever no transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |
| oe_n | input | NUM_OUT | Active-low output-enable pins, one per output |
| run | output | NUM_OUT | Run signal for each output |
| pd_hiz | output | 1 | Power-down drive-mode selection (1 = high impedance) |
| stop_hiz | output | 1 | Output-stop drive-mode selection (1 = high impedance) |

## Verification
Both bus lines pass through two synchroniser flops and an edge register, and the next-state flop adds one more, so the target pulls or releases SDA about four system clocks after the host lowers SCL. The bench therefore waits sixteen clocks before each SCL rise and reads SDA in the middle of the high phase. A register write takes effect at the SCL fall that closes its eighth bit, so pd_hiz, stop_hiz and run change within five clocks of that fall. run also follows oe_n combinationally in the same cycle. The bench holds its per-clock output comparison off for the whole of each transaction and applies writes to its model as each acknowledge arrives. It then compares every output on every clock while the bus is idle, sampling two time units after the rising edge.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_INDEX,
        ST_COUNT,
        ST_WDATA,
        ST_RDATA,
        ST_WAIT
    } xfer_st_e;

    localparam int unsigned BANK_BYTES = 7;

    localparam logic [7:0] IDX_MODE  = 8'd0;
    localparam logic [7:0] IDX_EN    = 8'd1;
    localparam logic [7:0] IDX_STOP  = 8'd2;
    localparam logic [7:0] IDX_RSVD  = 8'd3;
    localparam logic [7:0] IDX_ID    = 8'd4;
    localparam logic [7:0] IDX_DEV   = 8'd5;
    localparam logic [7:0] IDX_CNT   = 8'd6;

    localparam logic [7:0] MODE_MASK = 8'hC0;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    typedef struct packed {
        logic [STAGES-1:0] scl_ff;
        logic [STAGES-1:0] sda_ff;
        logic              scl_p;
        logic              sda_p;
    } sync_s;

    sync_s r_q, r_d;

    always_comb begin
        r_d        = r_q;
        r_d.scl_ff = {r_q.scl_ff[STAGES-2:0], scl_raw};
        r_d.sda_ff = {r_q.sda_ff[STAGES-2:0], sda_raw};
        r_d.scl_p  = r_q.scl_ff[STAGES-1];
        r_d.sda_p  = r_q.sda_ff[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_s    = r_q.scl_ff[STAGES-1];
    assign sda_s    = r_q.sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~r_q.scl_p;
    assign scl_fall = ~scl_s & r_q.scl_p;
    // data edges only count as conditions while the clock stays high
    assign start_ev = scl_s & r_q.scl_p & r_q.sda_p & ~sda_s;
    assign stop_ev  = scl_s & r_q.scl_p & ~r_q.sda_p & sda_s;

endmodule

// File: rtl/smb_cfg_bank.sv
module smb_cfg_bank
    import smb_cfg_pkg::*;
#(
    parameter int unsigned NUM_OUT   = 4,
    parameter logic [7:0]  DEV_CODE  = 8'h43,
    parameter logic [7:0]  ID_CODE   = 8'h11,
    parameter logic [7:0]  CNT_INIT  = 8'h07
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [7:0]         rd_idx,
    output logic [7:0]         rd_data,
    input  logic [NUM_OUT-1:0] oe_n,
    output logic [NUM_OUT-1:0] run,
    output logic               pd_hiz,
    output logic               stop_hiz
);

    localparam logic [7:0] OUT_MASK   = 8'((1 << NUM_OUT) - 1);
    localparam logic [7:0] MODE_INIT  = 8'h80;

    typedef struct packed {
        logic [7:0] mode;
        logic [7:0] en;
        logic [7:0] stp;
        logic [7:0] cnt;
    } bank_s;

    bank_s r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_idx)
                IDX_MODE: r_d.mode = wr_data & MODE_MASK;
                IDX_EN:   r_d.en   = wr_data & OUT_MASK;
                IDX_STOP: r_d.stp  = wr_data & OUT_MASK;
                IDX_CNT:  r_d.cnt  = wr_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode <= MODE_INIT;
            r_q.en   <= OUT_MASK;
            r_q.stp  <= 8'h00;
            r_q.cnt  <= CNT_INIT;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (rd_idx)
            IDX_MODE: rd_data = r_q.mode;
            IDX_EN:   rd_data = r_q.en;
            IDX_STOP: rd_data = r_q.stp;
            IDX_RSVD: rd_data = 8'h00;
            IDX_ID:   rd_data = ID_CODE;
            IDX_DEV:  rd_data = DEV_CODE;
            IDX_CNT:  rd_data = r_q.cnt;
            default:  rd_data = 8'h00;
        endcase
    end

    generate
        for (genvar g = 0; g < NUM_OUT; g++) begin : g_run
            assign run[g] = r_q.en[g] & (~r_q.stp[g] | ~oe_n[g]);
        end
    endgenerate

    assign pd_hiz   = r_q.mode[7];
    assign stop_hiz = r_q.mode[6];

endmodule

// File: rtl/smb_proto.sv
module smb_proto
    import smb_cfg_pkg::*;
#(
    parameter logic [7:0] WR_ADDR = 8'hDC,
    parameter logic [7:0] RD_ADDR = 8'hDD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       sda_s,
    input  logic [7:0] rd_data,
    output logic [7:0] rd_idx,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_data,
    output logic       sda_pull,
    output xfer_st_e   state_o
);

    localparam logic [3:0] BITS_FULL  = 4'd8;
    localparam logic [3:0] BITS_ACKED = 4'd9;

    typedef struct packed {
        xfer_st_e   st;
        logic [3:0] bits;
        logic       ack_ph;
        logic       host_ph;
        logic [7:0] shf;
        logic [7:0] idx;
        logic [7:0] rem;
        logic       pull;
    } proto_s;

    proto_s r_q, r_d;

    function automatic logic [7:0] idx_next(input logic [7:0] i);
        return (i == 8'hFF) ? i : i + 8'd1;
    endfunction

    always_comb begin
        r_d     = r_q;
        wr_en   = 1'b0;
        wr_idx  = r_q.idx;
        wr_data = r_q.shf;

        if (start_ev || stop_ev) begin
            r_d.st      = start_ev ? ST_ADDR : ST_IDLE;
            r_d.bits    = 4'd0;
            r_d.ack_ph  = 1'b0;
            r_d.host_ph = 1'b0;
            r_d.pull    = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
                    if (r_q.ack_ph) begin
                        if (scl_fall) begin
                            r_d.ack_ph = 1'b0;
                            r_d.pull   = 1'b0;
                        end
                    end else if (scl_rise && r_q.bits != BITS_FULL) begin
                        r_d.shf  = {r_q.shf[6:0], sda_s};
                        r_d.bits = r_q.bits + 4'd1;
                    end else if (scl_fall && r_q.bits == BITS_FULL) begin
                        r_d.bits   = 4'd0;
                        r_d.ack_ph = 1'b1;
                        r_d.pull   = 1'b1;
                        unique case (r_q.st)
                            ST_ADDR: begin
                                if (r_q.shf == WR_ADDR) begin
                                    r_d.st = ST_INDEX;
                                end else if (r_q.shf == RD_ADDR) begin
                                    r_d.st = ST_RDATA;
                                end else begin
                                    r_d.st     = ST_WAIT;
                                    r_d.ack_ph = 1'b0;
                                    r_d.pull   = 1'b0;
                                end
                            end
                            ST_INDEX: begin
                                r_d.idx = r_q.shf;
                                r_d.st  = ST_COUNT;
                            end
                            ST_COUNT: begin
                                r_d.rem = r_q.shf;
                                r_d.st  = ST_WDATA;
                            end
                            default: begin
                                if (r_q.rem != 8'd0) begin
                                    wr_en   = 1'b1;
                                    r_d.rem = r_q.rem - 8'd1;
                                    r_d.idx = idx_next(r_q.idx);
                                end else begin
                                    r_d.st     = ST_WAIT;
                                    r_d.ack_ph = 1'b0;
                                    r_d.pull   = 1'b0;
                                end
                            end
                        endcase
                    end
                end
                ST_RDATA: begin
                    if (r_q.ack_ph) begin
                        // end of address acknowledge: put the count byte out
                        if (scl_fall) begin
                            r_d.ack_ph = 1'b0;
                            r_d.shf    = rd_data;
                            r_d.pull   = ~rd_data[7];
                            r_d.bits   = 4'd1;
                        end
                    end else if (r_q.host_ph) begin
                        if (scl_rise) begin
                            if (sda_s) begin
                                r_d.st      = ST_WAIT;
                                r_d.host_ph = 1'b0;
                            end else begin
                                r_d.bits = BITS_ACKED;
                            end
                        end else if (scl_fall && r_q.bits == BITS_ACKED) begin
                            r_d.host_ph = 1'b0;
                            r_d.shf     = rd_data;
                            r_d.pull    = ~rd_data[7];
                            r_d.bits    = 4'd1;
                            r_d.idx     = idx_next(r_q.idx);
                        end
                    end else if (scl_fall) begin
                        if (r_q.bits == BITS_FULL) begin
                            r_d.host_ph = 1'b1;
                            r_d.pull    = 1'b0;
                        end else begin
                            r_d.shf  = {r_q.shf[6:0], 1'b0};
                            r_d.pull = ~r_q.shf[6];
                            r_d.bits = r_q.bits + 4'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, bits: 4'd0, ack_ph: 1'b0, host_ph: 1'b0,
                     shf: 8'h00, idx: 8'h00, rem: 8'h00, pull: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_idx   = (r_q.st == ST_RDATA && r_q.ack_ph) ? IDX_CNT : r_q.idx;
    assign sda_pull = r_q.pull;
    assign state_o  = r_q.st;

endmodule

// File: rtl/smb_cfg_target.sv
module smb_cfg_target
    import smb_cfg_pkg::*;
#(
    parameter int unsigned NUM_OUT     = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [7:0]  WR_ADDR     = 8'hDC,
    parameter logic [7:0]  DEV_CODE    = 8'h43,
    parameter logic [7:0]  ID_CODE     = 8'h11,
    parameter logic [7:0]  CNT_INIT    = 8'h07
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_pull,
    input  logic [NUM_OUT-1:0] oe_n,
    output logic [NUM_OUT-1:0] run,
    output logic               pd_hiz,
    output logic               stop_hiz
);

    localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;

    logic       scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    logic       wr_en;
    logic [7:0] wr_idx, wr_data, rd_idx, rd_data;
    xfer_st_e   xfer_state;

    smb_line_sync #(
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_in),
        .sda_raw  (sda_in),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    smb_proto #(
        .WR_ADDR  (WR_ADDR),
        .RD_ADDR  (RD_ADDR)
    ) u_proto (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_s    (sda_s),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .sda_pull (sda_pull),
        .state_o  (xfer_state)
    );

    smb_cfg_bank #(
        .NUM_OUT  (NUM_OUT),
        .DEV_CODE (DEV_CODE),
        .ID_CODE  (ID_CODE),
        .CNT_INIT (CNT_INIT)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .oe_n     (oe_n),
        .run      (run),
        .pd_hiz   (pd_hiz),
        .stop_hiz (stop_hiz)
    );

endmodule

// File: rtl/smb_cfg_checker.sv
module smb_cfg_checker
    import smb_cfg_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input xfer_st_e state,
    input logic     sda_pull,
    input logic     scl_s,
    input logic     start_ev,
    input logic     stop_ev,
    input logic     wr_en,
    input logic     pd_hiz,
    input logic     stop_hiz
);

    // R11: the data line never moves while the synchronised clock is high
    a_r11_pull_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_pull));

    // R1 / R11: an idle or ignoring target never pulls the line
    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WAIT) |-> !sda_pull);

    // R8: a stop returns the engine to idle, a start to address decode
    a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_pull));

    a_r8_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));

    // R2: register writes only come out of the data phase
    a_r2_write_in_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (state == ST_WDATA));

    // R10: drive-mode outputs move only after a write strobe
    a_r10_mode_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(pd_hiz) && $stable(stop_hiz)));

endmodule

bind smb_cfg_target smb_cfg_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (xfer_state),
    .sda_pull (sda_pull),
    .scl_s    (scl_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .wr_en    (wr_en),
    .pd_hiz   (pd_hiz),
    .stop_hiz (stop_hiz)
);

// File: tb/smb_cfg_target_tb.sv
module smb_cfg_target_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int HB         = 16;
    localparam int NOUT       = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            scl = 1'b1;
    logic            sda_h = 1'b1;
    logic            sda_line;
    logic            sda_pull;
    logic [NOUT-1:0] oe_n = '1;
    logic [NOUT-1:0] run;
    logic            pd_hiz, stop_hiz;

    int   tests = 0;
    int   fails = 0;
    bit   hold  = 1'b1;
    bit   done  = 1'b0;
    logic [7:0] mdl [0:6];
    logic [7:0] rb  [0:15];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line = sda_h & ~sda_pull;

    smb_cfg_target #(.NUM_OUT(NOUT)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .oe_n     (oe_n),
        .run      (run),
        .pd_hiz   (pd_hiz),
        .stop_hiz (stop_hiz)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] wmask(input int i);
        case (i)
            0:       return 8'hC0;
            1, 2:    return 8'h0F;
            6:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [NOUT-1:0] exp_run();
        logic [NOUT-1:0] r;
        for (int i = 0; i < NOUT; i++)
            r[i] = mdl[1][i] & (~mdl[2][i] | ~oe_n[i]);
        return r;
    endfunction

    // per-clock comparison against the model while the bus is quiet
    always @(posedge clk) begin
        #2;
        if (rst_n && !hold && !done) begin
            chk("R9 run vs model", run, exp_run());
            chk("R10 pd_hiz vs model", pd_hiz, mdl[0][7]);
            chk("R10 stop_hiz vs model", stop_hiz, mdl[0][6]);
            chk("R11 line released when idle", sda_pull, 1'b0);
        end
    end

    task automatic hb();
        repeat (HB) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; hb();
        scl = 1'b1; hb();
        sda_h = 1'b0; hb();
        scl = 1'b0; repeat (2) @(negedge clk);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; hb();
        scl = 1'b1; hb();
        sda_h = 1'b1; hb();
    endtask

    task automatic tx_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_h = b[i]; hb();
            scl = 1'b1; hb();
            scl = 1'b0; repeat (2) @(negedge clk);
        end
    endtask

    task automatic tx_byte(input logic [7:0] b, output logic ack);
        tx_bits(b, 8);
        sda_h = 1'b1; hb();
        scl = 1'b1; repeat (HB/2) @(negedge clk);
        ack = (sda_line == 1'b0);
        repeat (HB/2) @(negedge clk);
        scl = 1'b0; repeat (2) @(negedge clk);
    endtask

    task automatic rx_byte(input logic nack, output logic [7:0] b);
        sda_h = 1'b1;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            hb();
            scl = 1'b1; repeat (HB/2) @(negedge clk);
            b = {b[6:0], sda_line};
            repeat (HB/2) @(negedge clk);
            scl = 1'b0; repeat (2) @(negedge clk);
        end
        sda_h = nack; hb();
        scl = 1'b1; hb();
        scl = 1'b0; repeat (2) @(negedge clk);
        sda_h = 1'b1;
    endtask

    task automatic apply_write(input int idx, input logic [7:0] d);
        if (idx < 7) mdl[idx] = (mdl[idx] & ~wmask(idx)) | (d & wmask(idx));
    endtask

    task automatic blk_write(input int idx, input int cnt, input logic [7:0] d [], input string tag);
        logic a;
        hold = 1'b1;
        bus_start();
        tx_byte(8'hDC, a); chk({tag, " R1 write address ack"}, a, 1'b1);
        tx_byte(8'(idx), a); chk({tag, " R2 index ack"}, a, 1'b1);
        tx_byte(8'(cnt), a); chk({tag, " R2 count ack"}, a, 1'b1);
        foreach (d[k]) begin
            tx_byte(d[k], a);
            chk({tag, " R3 data ack per count"}, a, (k < cnt));
            if (k < cnt) apply_write(idx + k, d[k]);
        end
        bus_stop();
        hold = 1'b0;
    endtask

    task automatic blk_read(input int idx, input int n);
        logic a;
        hold = 1'b1;
        bus_start();
        tx_byte(8'hDC, a); chk("R1 write address ack", a, 1'b1);
        tx_byte(8'(idx), a); chk("R4 index ack", a, 1'b1);
        bus_start();
        tx_byte(8'hDD, a); chk("R1 read address ack", a, 1'b1);
        for (int k = 0; k < n; k++) rx_byte(k == n - 1, rb[k]);
        hb();
        chk("R4 released after host nack", sda_pull, 1'b0);
        bus_stop();
        hold = 1'b0;
    endtask

    task automatic expect_read(input int idx, input logic [7:0] e [], input string tag);
        blk_read(idx, e.size());
        foreach (e[k]) chk({tag, " read byte"}, rb[k], e[k]);
    endtask

    initial begin
        logic a;
        mdl[0] = 8'h80; mdl[1] = 8'h0F; mdl[2] = 8'h00; mdl[3] = 8'h00;
        mdl[4] = 8'h11; mdl[5] = 8'h43; mdl[6] = 8'h07;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5: reset state at the ports
        chk("R5 run after reset", run, 4'hF);
        chk("R5 pd_hiz after reset", pd_hiz, 1'b1);
        chk("R5 stop_hiz after reset", stop_hiz, 1'b0);
        chk("R5 line released after reset", sda_pull, 1'b0);
        hold = 1'b0;

        // R5 / R4: full read from index 0, count byte first
        expect_read(0, '{8'h07, 8'h80, 8'h0F, 8'h00, 8'h00, 8'h11, 8'h43, 8'h07}, "R5 R4");

        // R1: foreign address is ignored
        hold = 1'b1;
        bus_start();
        tx_byte(8'hA0, a); chk("R1 foreign address nack", a, 1'b0);
        tx_byte(8'h00, a); chk("R1 silent after foreign address", a, 1'b0);
        bus_stop();
        hold = 1'b0;

        // R2: block write then readback
        blk_write(1, 2, '{8'h0A, 8'h05}, "R2");
        expect_read(1, '{8'h07, 8'h0A, 8'h05, 8'h00}, "R2");
        for (int v = 0; v < 16; v++) begin
            oe_n = 4'(v);
            repeat (6) @(negedge clk);
        end
        oe_n = 4'hF; #1;
        chk("R9 disabled outputs stay low", run, 4'hA);

        // R6 / R10: masked and read-only bits
        blk_write(0, 1, '{8'hFF}, "R6");
        repeat (4) @(negedge clk);
        chk("R10 pd_hiz set", pd_hiz, 1'b1);
        chk("R10 stop_hiz set", stop_hiz, 1'b1);
        blk_write(3, 3, '{8'hFF, 8'hFF, 8'hFF}, "R6");
        expect_read(3, '{8'h07, 8'h00, 8'h11, 8'h43}, "R6");
        blk_write(0, 1, '{8'h7F}, "R6");
        expect_read(0, '{8'h07, 8'h40}, "R6 R10");
        chk("R10 pd_hiz cleared", pd_hiz, 1'b0);

        // R3: bytes past the count are refused
        blk_write(1, 1, '{8'h0F, 8'h03}, "R3");
        expect_read(1, '{8'h07, 8'h0F, 8'h05}, "R3");

        // R9: stoppable outputs follow the pins
        blk_write(2, 1, '{8'h0A}, "R9");
        oe_n = 4'hF; #1;
        chk("R9 stoppable outputs stopped", run, 4'h5);
        oe_n = 4'h0; #1;
        chk("R9 all pins asserted", run, 4'hF);
        oe_n = 4'h8; #1;
        chk("R9 mixed pins", run, 4'h7);
        repeat (4) @(negedge clk);

        // R7: out-of-range index
        blk_write(6, 2, '{8'h03, 8'hAA}, "R7");
        expect_read(5, '{8'h03, 8'h43, 8'h03, 8'h00}, "R7");

        // R8: stop in the middle of a data byte
        hold = 1'b1;
        bus_start();
        tx_byte(8'hDC, a); chk("R8 address ack", a, 1'b1);
        tx_byte(8'h01, a); chk("R8 index ack", a, 1'b1);
        tx_byte(8'h02, a); chk("R8 count ack", a, 1'b1);
        tx_byte(8'h00, a); chk("R8 first data ack", a, 1'b1);
        apply_write(1, 8'h00);
        tx_bits(8'hFF, 3);
        bus_stop();
        hold = 1'b0;
        expect_read(1, '{8'h03, 8'h00, 8'h0A}, "R8 stop abort");

        // R8: start in the middle of the index byte
        hold = 1'b1;
        bus_start();
        tx_byte(8'hDC, a); chk("R8 address ack", a, 1'b1);
        tx_bits(8'h55, 4);
        hold = 1'b0;
        blk_write(2, 1, '{8'h05}, "R8 restart");
        expect_read(2, '{8'h03, 8'h05}, "R8 restart");

        repeat (20) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule